// File: doc/BRIEF.md
# Ethernet MAC Transmit Frame Sequencer

The sequencer drives the transmit side of an Ethernet MAC. An external queue controller pushes frame bytes into an internal retention buffer. The sequencer turns them into a nibble stream on an MII-style transmit interface. It sends one nibble per clock and wraps each frame in a preamble and start delimiter. Short frames get zero padding, and a CRC-32 frame check sequence is appended when the frame asks for one.

A frame starts only when three things hold: software has enabled transmission and is not asking for a halt, the medium-free handshake is high, and enough of the frame is buffered. Enough means the programmed preload count has been reached, or the whole frame is already in the buffer.

Until 64 body bytes have gone out, the start of the frame stays in the buffer. A collision in that window therefore rewinds the frame for a full retry. Gap timing and backoff timing stay outside the block and are fed in through the medium-free input. A queue-side error, or a buffer underrun, ends the frame with a transmit-error nibble, and the rest of that frame is discarded.

Top module: `eth_tx_sequencer`

## Requirements
- R1: A frame starts only when `cfg_tx_en`=1, `cfg_tx_halt`=0 and `medium_free`=1 are all seen two cycles before `mii_tx_en` rises; while any of them is off, nothing is sent.
- R2: A frame starts only when the buffered byte count of the frame is nonzero and either at least `cfg_preload` or includes the frame's last byte.
- R3: Every attempt begins with 15 nibbles of 0x5 and then one nibble of 0xD on `mii_txd`. The first nibble appears in the cycle `mii_tx_en` rises.
- R4: After the delimiter, each frame byte is sent low nibble first, one nibble per clock, with `mii_tx_en` held high without a gap.
- R5: If a frame has fewer than 60 body bytes, zero bytes are added until the body is 60 bytes long.
- R6: A frame check sequence is appended only when `q_fcs`=1 accompanies the last byte. It is 8 nibbles, low nibble first, of the complemented reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) over the body, including the padding.
- R7: A `col_det` seen while fewer than 64 body bytes have been sent drops `mii_tx_en` on the next cycle. The frame is then resent complete, from its first byte.
- R8: A `col_det` seen after 64 body bytes have been sent has no effect on the output stream.
- R9: A queue entry pushed with `q_err`=1, or an empty buffer when the next byte is due, produces one nibble with `mii_tx_er`=1 and `mii_tx_en`=1, and a one-cycle `tx_abort`. `mii_tx_en` then drops, the remaining bytes of that frame are discarded, and no `tx_done` follows.
- R10: `tx_done` pulses for one cycle together with the last nibble of a completed frame, and `mii_tx_en` is low in the next cycle. `tx_done` and `tx_abort` are never high together.
- R11: `q_ready` is low while the retained bytes fill the buffer, and from the moment a frame's last or error entry is accepted until that frame completes or aborts.
- R12: After reset, `mii_tx_en`, `mii_tx_er`, `tx_done` and `tx_abort` are 0 and `q_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable control |
| cfg_tx_halt | input | 1 | Request to hold off new frames |
| cfg_preload | input | PRE_W | Bytes buffered before a start |
| medium_free | input | 1 | Gap and backoff timing done, medium may be taken |
| col_det | input | 1 | Collision indication |
| q_valid | input | 1 | Queue entry valid |
| q_data | input | 8 | Frame byte |
| q_last | input | 1 | Entry is the last byte of the frame |
| q_fcs | input | 1 | With the last byte: append the check sequence |
| q_err | input | 1 | Entry marks a queue-side error and ends the frame |
| q_ready | output | 1 | Buffer accepts an entry |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| mii_tx_er | output | 1 | Transmit error |
| tx_done | output | 1 | Completion status pulse |
| tx_abort | output | 1 | Abort pulse |

## Verification
The assertions check on every cycle that every start was gated by enable, halt, medium and preload conditions, that every attempt opens with a preamble nibble, and that the transmit-error signal never appears without transmit enable. They also check that an early collision silences the line one cycle later, that completion ends the burst, and that the retained bytes never exceed the buffer. The exact nibble contents can only be shown by the bench's scenarios, which compare whole nibble streams against independently built frames. These scenarios cover padding, the CRC, the full resend after an early collision, the ignored late collision, and the discarding of the tail after an error or an underrun.

// File: rtl/eth_tx_pkg.sv
// Shared types and helpers for the transmit frame sequencer.
// Assumes nibble-serial operation, least significant bit first.
package eth_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DATA,
        S_PAD,
        S_FCS,
        S_FLUSH
    } tx_state_e;

    typedef struct packed {
        logic       err;
        logic       fcs;
        logic       last;
        logic [7:0] data;
    } tx_entry_t;

    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam int          MIN_BODY  = 60;
    localparam int          ACQ_BYTES = 64;
    localparam int          PRE_NIBS  = 16;

    // Advance a reflected CRC-32 by four data bits, bit 0 first.
    function automatic logic [31:0] crc_nib(input logic [31:0] c, input logic [3:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 4; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_rbuf.sv
// Retention buffer: one write port, one asynchronous read port.
// Assumes the caller manages pointers and never overwrites live entries.
module eth_tx_rbuf
    import eth_tx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  tx_entry_t       wdata,
    input  logic [AW-1:0]   raddr,
    output tx_entry_t       rdata
);
    tx_entry_t mem [DEPTH];

    // Store an accepted queue entry.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eth_tx_crc.sv
// Nibble-serial CRC-32 generator for the frame check sequence.
// init restarts the remainder; upd folds in a nibble; shift exposes the
// next complemented check nibble on fcs_nib.
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       upd,
    input  logic       shift,
    input  logic [3:0] nib_in,
    output logic [3:0] fcs_nib
);
    logic [31:0] crc_q;

    // Hold the running remainder, or shift it out a nibble at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= '1;
        else if (init)  crc_q <= '1;
        else if (upd)   crc_q <= crc_nib(crc_q, nib_in);
        else if (shift) crc_q <= {4'h0, crc_q[31:4]};
    end

    assign fcs_nib = ~crc_q[3:0];
endmodule

// File: rtl/eth_tx_sequencer.sv
// Transmit frame sequencer: buffers queue entries and emits nibbles with
// preamble, padding and optional check sequence. The frame start is held
// in the buffer until 64 body bytes are out, so early collisions rewind.
// Assumes only one frame is queued at a time: q_ready falls once its end
// entry is taken. Gap timing and backoff arrive through medium_free.
module eth_tx_sequencer
    import eth_tx_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_tx_en,
    input  logic             cfg_tx_halt,
    input  logic [PRE_W-1:0] cfg_preload,
    input  logic             medium_free,
    input  logic             col_det,
    input  logic             q_valid,
    input  logic [7:0]       q_data,
    input  logic             q_last,
    input  logic             q_fcs,
    input  logic             q_err,
    output logic             q_ready,
    output logic [3:0]       mii_txd,
    output logic             mii_tx_en,
    output logic             mii_tx_er,
    output logic             tx_done,
    output logic             tx_abort
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    tx_state_e      state, st_n;
    logic [PW-1:0]  wr_ptr, rd_ptr, base_ptr, rd_n, base_n;
    logic [PW-1:0]  hold_ptr, held, frame_cnt;
    logic [3:0]     nib_cnt, nib_cnt_n;
    logic           ph, ph_n;
    logic [6:0]     byte_cnt, byte_n;
    logic           fcs_sel, fcs_sel_n;
    logic           end_in, end_clr;
    logic           acquired, tx_busy, buf_empty, push, start;
    logic [3:0]     nib_now, fcs_nib;
    logic           en_now, er_now, done_now, abort_now;
    logic           crc_init, crc_upd, crc_shift;
    tx_entry_t      ent, wr_ent;

    assign acquired  = (byte_cnt == 7'(ACQ_BYTES));
    assign hold_ptr  = acquired ? rd_ptr : base_ptr;
    assign held      = wr_ptr - hold_ptr;
    assign frame_cnt = wr_ptr - base_ptr;
    assign q_ready   = (held != PW'(DEPTH)) && !end_in;
    assign push      = q_valid && q_ready;
    assign buf_empty = (rd_ptr == wr_ptr);
    assign tx_busy   = (state == S_PRE) || (state == S_DATA) ||
                       (state == S_PAD) || (state == S_FCS);
    assign start     = cfg_tx_en && !cfg_tx_halt && medium_free &&
                       (frame_cnt != '0) &&
                       ((frame_cnt >= PW'(cfg_preload)) || end_in);
    assign wr_ent    = '{err: q_err, fcs: q_fcs, last: q_last, data: q_data};

    eth_tx_rbuf #(.DEPTH(DEPTH)) u_rbuf (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr[AW-1:0]),
        .wdata (wr_ent),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (ent)
    );

    eth_tx_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .upd     (crc_upd),
        .shift   (crc_shift),
        .nib_in  (nib_now),
        .fcs_nib (fcs_nib)
    );

    // Next state, pointer moves and the nibble for this cycle.
    always_comb begin
        st_n      = state;
        rd_n      = rd_ptr;
        base_n    = base_ptr;
        nib_cnt_n = nib_cnt;
        ph_n      = ph;
        byte_n    = byte_cnt;
        fcs_sel_n = fcs_sel;
        nib_now   = 4'h0;
        en_now    = 1'b0;
        er_now    = 1'b0;
        done_now  = 1'b0;
        abort_now = 1'b0;
        end_clr   = 1'b0;
        crc_init  = 1'b0;
        crc_upd   = 1'b0;
        crc_shift = 1'b0;
        if (tx_busy && col_det && !acquired) begin
            st_n   = S_IDLE;
            rd_n   = base_ptr;
            byte_n = '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    st_n      = S_PRE;
                    nib_cnt_n = '0;
                    ph_n      = 1'b0;
                    byte_n    = '0;
                    crc_init  = 1'b1;
                end
                S_PRE: begin
                    en_now    = 1'b1;
                    nib_now   = (nib_cnt == 4'(PRE_NIBS - 1)) ? 4'hD : 4'h5;
                    nib_cnt_n = nib_cnt + 4'd1;
                    if (nib_cnt == 4'(PRE_NIBS - 1)) st_n = S_DATA;
                end
                S_DATA: begin
                    en_now = 1'b1;
                    if (!ph) begin
                        if (buf_empty || ent.err) begin
                            er_now    = 1'b1;
                            abort_now = 1'b1;
                            st_n      = S_FLUSH;
                        end else begin
                            nib_now = ent.data[3:0];
                            crc_upd = 1'b1;
                            ph_n    = 1'b1;
                        end
                    end else begin
                        nib_now = ent.data[7:4];
                        crc_upd = 1'b1;
                        ph_n    = 1'b0;
                        rd_n    = rd_ptr + 1'b1;
                        if (!acquired) byte_n = byte_cnt + 7'd1;
                        if (ent.last) begin
                            fcs_sel_n = ent.fcs;
                            nib_cnt_n = '0;
                            if (byte_cnt + 7'd1 < 7'(MIN_BODY)) st_n = S_PAD;
                            else if (ent.fcs)                   st_n = S_FCS;
                            else begin
                                done_now = 1'b1;
                                end_clr  = 1'b1;
                                base_n   = rd_ptr + 1'b1;
                                st_n     = S_IDLE;
                            end
                        end
                    end
                end
                S_PAD: begin
                    en_now  = 1'b1;
                    crc_upd = 1'b1;
                    ph_n    = !ph;
                    if (ph) begin
                        byte_n = byte_cnt + 7'd1;
                        if (byte_cnt + 7'd1 == 7'(MIN_BODY)) begin
                            if (fcs_sel) st_n = S_FCS;
                            else begin
                                done_now = 1'b1;
                                end_clr  = 1'b1;
                                base_n   = rd_ptr;
                                st_n     = S_IDLE;
                            end
                        end
                    end
                end
                S_FCS: begin
                    en_now    = 1'b1;
                    nib_now   = fcs_nib;
                    crc_shift = 1'b1;
                    nib_cnt_n = nib_cnt + 4'd1;
                    if (nib_cnt == 4'd7) begin
                        done_now = 1'b1;
                        end_clr  = 1'b1;
                        base_n   = rd_ptr;
                        st_n     = S_IDLE;
                    end
                end
                S_FLUSH: if (!buf_empty) begin
                    rd_n = rd_ptr + 1'b1;
                    if (ent.last || ent.err) begin
                        base_n  = rd_ptr + 1'b1;
                        end_clr = 1'b1;
                        byte_n  = '0;
                        st_n    = S_IDLE;
                    end
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    // Register control state, pointers and the MII outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            base_ptr  <= '0;
            nib_cnt   <= '0;
            ph        <= 1'b0;
            byte_cnt  <= '0;
            fcs_sel   <= 1'b0;
            end_in    <= 1'b0;
            mii_txd   <= 4'h0;
            mii_tx_en <= 1'b0;
            mii_tx_er <= 1'b0;
            tx_done   <= 1'b0;
            tx_abort  <= 1'b0;
        end else begin
            state     <= st_n;
            rd_ptr    <= rd_n;
            base_ptr  <= base_n;
            nib_cnt   <= nib_cnt_n;
            ph        <= ph_n;
            byte_cnt  <= byte_n;
            fcs_sel   <= fcs_sel_n;
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (end_clr)                       end_in <= 1'b0;
            else if (push && (q_last || q_err)) end_in <= 1'b1;
            mii_txd   <= nib_now;
            mii_tx_en <= en_now;
            mii_tx_er <= er_now;
            tx_done   <= done_now;
            tx_abort  <= abort_now;
        end
    end
endmodule

// File: rtl/eth_tx_seq_chk.sv
// Property checker for the transmit frame sequencer, bound to every
// instance. Observes ports and a few internal buffer signals.
module eth_tx_seq_chk #(
    parameter int DEPTH = 128,
    parameter int PRE_W = 7,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_tx_en,
    input logic             cfg_tx_halt,
    input logic [PRE_W-1:0] cfg_preload,
    input logic             medium_free,
    input logic             col_det,
    input logic             tx_busy,
    input logic             acquired,
    input logic             end_in,
    input logic [PW-1:0]    frame_cnt,
    input logic [PW-1:0]    held,
    input logic [3:0]       mii_txd,
    input logic             mii_tx_en,
    input logic             mii_tx_er,
    input logic             tx_done,
    input logic             tx_abort
);
    // R1
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> $past(cfg_tx_en && !cfg_tx_halt && medium_free, 2));

    // R2
    start_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> $past((frame_cnt != '0) &&
            ((frame_cnt >= PW'(cfg_preload)) || end_in), 2));

    // R3
    first_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> (mii_txd == 4'h5));

    // R7
    early_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_det && tx_busy && !acquired) |=> !mii_tx_en);

    // R9
    er_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mii_tx_er |-> mii_tx_en);

    // R10
    done_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !mii_tx_en);

    // R10
    done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_abort));

    // R11
    held_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held <= PW'(DEPTH));
endmodule

bind eth_tx_sequencer eth_tx_seq_chk #(.DEPTH(DEPTH), .PRE_W(PRE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_tx_en   (cfg_tx_en),
    .cfg_tx_halt (cfg_tx_halt),
    .cfg_preload (cfg_preload),
    .medium_free (medium_free),
    .col_det     (col_det),
    .tx_busy     (tx_busy),
    .acquired    (acquired),
    .end_in      (end_in),
    .frame_cnt   (frame_cnt),
    .held        (held),
    .mii_txd     (mii_txd),
    .mii_tx_en   (mii_tx_en),
    .mii_tx_er   (mii_tx_er),
    .tx_done     (tx_done),
    .tx_abort    (tx_abort)
);

// File: tb/tb_eth_tx_sequencer.sv
// Bench: directed corner cases plus seeded random frames, with the
// expected nibble stream of every frame built by bench functions.
module tb_eth_tx_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;
    localparam int PRE_W      = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_tx_en = 1'b0, cfg_tx_halt = 1'b0, medium_free = 1'b1;
    logic [PRE_W-1:0] cfg_preload = 7'd8;
    logic             col_det = 1'b0;
    logic             q_valid = 1'b0, q_last = 1'b0, q_fcs = 1'b0, q_err = 1'b0;
    logic [7:0]       q_data = 8'h00;
    logic             q_ready;
    logic [3:0]       mii_txd;
    logic             mii_tx_en, mii_tx_er, tx_done, tx_abort;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eth_tx_sequencer #(.DEPTH(DEPTH), .PRE_W(PRE_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_tx_halt(cfg_tx_halt),
        .cfg_preload(cfg_preload), .medium_free(medium_free), .col_det(col_det),
        .q_valid(q_valid), .q_data(q_data), .q_last(q_last), .q_fcs(q_fcs),
        .q_err(q_err), .q_ready(q_ready), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
        .mii_tx_er(mii_tx_er), .tx_done(tx_done), .tx_abort(tx_abort));

    int checks = 0, fails = 0;
    logic [7:0] frm [256];
    logic [3:0] cap [1024];
    logic [3:0] expn [1024];
    int cap_n = 0, exp_n = 0, bursts = 0, done_cnt = 0, abort_cnt = 0;
    bit er_seen = 0, prev_en = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: collects the nibbles of the latest burst and counts pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mii_tx_en) begin
                if (!prev_en) begin cap_n = 0; bursts++; end
                cap[cap_n] = mii_txd;
                cap_n++;
                if (mii_tx_er) er_seen = 1;
            end
            prev_en = mii_tx_en;
            if (tx_done)  done_cnt++;
            if (tx_abort) abort_cnt++;
        end
    end

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++)
            r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    // Expected burst for frm[0..len-1]: preamble, body, pad, optional FCS.
    task automatic build_exp(input int len, input bit fcs);
        logic [31:0] c;
        int body;
        logic [7:0] b;
        exp_n = 0;
        for (int i = 0; i < 15; i++) begin expn[exp_n] = 4'h5; exp_n++; end
        expn[exp_n] = 4'hD; exp_n++;
        body = (len < 60) ? 60 : len;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < body; i++) begin
            b = (i < len) ? frm[i] : 8'h00;
            c = crc_byte(c, b);
            expn[exp_n] = b[3:0]; exp_n++;
            expn[exp_n] = b[7:4]; exp_n++;
        end
        if (fcs) begin
            c = ~c;
            for (int i = 0; i < 8; i++) begin expn[exp_n] = c[4*i +: 4]; exp_n++; end
        end
    endtask

    task automatic compare(input string tag);
        int bad, first;
        bad = 0; first = -1;
        check(cap_n == exp_n, tag, "burst length", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (cap[i] !== expn[i]) begin bad++; if (first < 0) first = i; end
        if (first < 0) first = 0;
        check(bad == 0, tag, "nibble content", int'(cap[first]), int'(expn[first]));
    endtask

    task automatic push_byte(input logic [7:0] d, input bit last, input bit fcs, input bit err);
        @(negedge clk);
        q_valid = 1; q_data = d; q_last = last; q_fcs = fcs; q_err = err;
        while (!q_ready) @(negedge clk);
        @(posedge clk);
        #1 q_valid = 0; q_last = 0; q_fcs = 0; q_err = 0;
    endtask

    task automatic push_range(input int from, input int to, input int len, input bit fcs);
        for (int i = from; i < to; i++) push_byte(frm[i], i == len - 1, fcs, 1'b0);
    endtask

    task automatic fill_frame(input int len);
        for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
    endtask

    task automatic wait_end(input string tag);
        int d0, a0, n;
        d0 = done_cnt; a0 = abort_cnt; n = 0;
        while (done_cnt == d0 && abort_cnt == a0 && n < 4000) begin @(negedge clk); n++; end
        check(n < 4000, tag, "frame end seen", n, 0);
        @(negedge clk);
    endtask

    task automatic run_frame(input int len, input bit fcs, input string tag);
        int d0;
        d0 = done_cnt;
        fill_frame(len);
        build_exp(len, fcs);
        push_range(0, len, len, fcs);
        wait_end(tag);
        compare(tag);
        check(done_cnt == d0 + 1, tag, "done pulses", done_cnt - d0, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        int b0, d0, a0, len;
        bit f;
        void'($urandom(32'h5EED));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R12: reset state
        check(mii_tx_en == 0 && mii_tx_er == 0, "R12", "tx_en/tx_er", mii_tx_en, 0);
        check(tx_done == 0 && tx_abort == 0, "R12", "status pulses", tx_done, 0);
        check(q_ready == 1, "R12", "q_ready", q_ready, 1);

        // R1: disabled, halted, medium busy: no start
        fill_frame(10); build_exp(10, 1);
        push_range(0, 10, 10, 1);
        // R11: end entry stored, no further entries accepted
        check(q_ready == 0, "R11", "q_ready after last", q_ready, 0);
        repeat (40) @(negedge clk);
        check(bursts == 0, "R1", "bursts while disabled", bursts, 0);
        cfg_tx_en = 1; cfg_tx_halt = 1;
        repeat (40) @(negedge clk);
        check(bursts == 0, "R1", "bursts while halted", bursts, 0);
        cfg_tx_halt = 0; medium_free = 0;
        repeat (40) @(negedge clk);
        check(bursts == 0, "R1", "bursts while medium busy", bursts, 0);
        medium_free = 1;
        wait_end("R1");
        // R3 R5 R6: short frame padded to 60 with FCS
        compare("R5_R6");

        // R5: short frame, no FCS
        run_frame(10, 0, "R5");
        // R2: whole short frame below preload still starts
        cfg_preload = 7'd40;
        run_frame(12, 1, "R2");

        // R2: preload threshold holds a long frame back
        cfg_preload = 7'd20;
        fill_frame(40); build_exp(40, 1);
        b0 = bursts;
        push_range(0, 19, 40, 1);
        repeat (30) @(negedge clk);
        check(bursts == b0, "R2", "start below preload", bursts - b0, 0);
        push_range(19, 40, 40, 1);
        wait_end("R2");
        compare("R2");

        // R7: early collision rewinds and resends the whole frame
        cfg_preload = 7'd16;
        fill_frame(80); build_exp(80, 1);
        b0 = bursts; d0 = done_cnt;
        fork
            push_range(0, 80, 80, 1);
            begin
                wait (mii_tx_en == 1);
                repeat (40) @(negedge clk);
                col_det = 1; @(negedge clk); col_det = 0;
            end
        join
        wait_end("R7");
        check(bursts == b0 + 2, "R7", "attempts", bursts - b0, 2);
        compare("R7");
        check(done_cnt == d0 + 1, "R7", "done pulses", done_cnt - d0, 1);

        // R8: late collision ignored
        fill_frame(100); build_exp(100, 0);
        b0 = bursts;
        fork
            push_range(0, 100, 100, 0);
            begin
                wait (mii_tx_en == 1);
                repeat (170) @(negedge clk);
                col_det = 1; @(negedge clk); col_det = 0;
            end
        join
        wait_end("R8");
        check(bursts == b0 + 1, "R8", "attempts", bursts - b0, 1);
        compare("R8");

        // R9: error entry aborts with one error nibble
        cfg_preload = 7'd8;
        fill_frame(20);
        d0 = done_cnt; a0 = abort_cnt; er_seen = 0;
        push_range(0, 20, 99, 0);
        push_byte(8'h00, 0, 0, 1);
        wait_end("R9");
        check(er_seen == 1, "R9", "tx_er seen", er_seen, 1);
        check(abort_cnt == a0 + 1 && done_cnt == d0, "R9", "abort without done",
              abort_cnt - a0, 1);
        check(cap_n == 16 + 40 + 1, "R9", "aborted burst length", cap_n, 57);

        // R9: underrun aborts, the frame tail is discarded
        cfg_preload = 7'd4;
        fill_frame(30);
        a0 = abort_cnt;
        push_range(0, 5, 30, 0);
        wait_end("R9");
        check(abort_cnt == a0 + 1, "R9", "underrun abort", abort_cnt - a0, 1);
        check(cap_n == 16 + 10 + 1, "R9", "underrun burst length", cap_n, 27);
        b0 = bursts;
        push_range(5, 30, 30, 0);
        repeat (30) @(negedge clk);
        check(bursts == b0, "R9", "tail discarded", bursts - b0, 0);
        run_frame(15, 1, "R9");

        // R4 R6 R10: seeded random frames and preloads
        for (int k = 0; k < 12; k++) begin
            len = 1 + int'($urandom % 150);
            f = 1'($urandom);
            cfg_preload = 7'(1 + ($urandom % 64));
            run_frame(len, f, "R4_R10");
        end
        // R6: exactly 60-byte body, no pad, with FCS
        run_frame(60, 1, "R6");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule